// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is one counter field of a register file. Hardware moves the count through two strobes, one for counting up and one for counting down. Each direction has its own step source, picked at build time: a unit step, a constant step, or a step read from a narrow amount input while its strobe is high. When both strobes are high in the same cycle, the counter applies the difference of the two steps.

Each direction can be set to saturate or to wrap. A saturating up-count stops at a configurable ceiling, which defaults to the all-ones value. A saturating down-count stops at a configurable floor, which defaults to zero. A direction that wraps instead gives a one-cycle overflow or underflow pulse each time the count passes the end of its range. Two level flags, each with its own configurable threshold, show when the count is at or above an upper threshold and when it is at or below a lower one. Software can load the count through a decoded write port. A write wins over any counting in that cycle.

Top module: `ctr_field`

## Requirements
- R1: After reset the count is 0 and both pulses are low. The level flags then follow R9 and R10 for a count of 0.
- R2: While the up strobe is high, the up step is added to the count on the next clock edge. The up step comes from one of three modes:
  - unit: a step of 1;
  - fixed: the step is the parameter INC_FIXED;
  - variable: the step is `incr_amt` zero-extended to W bits.
- R3: While the down strobe is high, the down step is subtracted on the next edge. The down step has the same three modes: unit, fixed with the parameter DEC_FIXED, or variable from `decr_amt`.
- R4: When both strobes are high, the count changes by the up step minus the down step. A net change of zero leaves the count unchanged.
- R5: With up saturation on, a net increase that would pass INC_CEIL leaves the count at INC_CEIL. INC_CEIL defaults to 2^W-1.
- R6: With down saturation on, a net decrease that would go below DEC_FLOOR leaves the count at DEC_FLOOR. DEC_FLOOR defaults to 0.
- R7: With up saturation off, a net increase past 2^W-1 wraps modulo 2^W. `ovf_pulse` is then high for the one cycle that follows that edge.
- R8: With down saturation off, a net decrease below 0 wraps modulo 2^W. `unf_pulse` is then high for the one cycle that follows that edge.
- R9: `at_upper` is high exactly while the count is greater than or equal to INC_THR. INC_THR defaults to 2^W-1.
- R10: `at_lower` is high exactly while the count is less than or equal to DEC_THR. DEC_THR defaults to 0.
- R11: A cycle with `wr_en` high loads `wr_data` into the count and ignores both strobes. Both pulses are low after that edge.
- R12: With no strobe and no write, the count holds its value and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| incr_stb | input | 1 | Count-up strobe |
| incr_amt | input | INC_VW | Variable up step (used in variable mode) |
| decr_stb | input | 1 | Count-down strobe |
| decr_amt | input | DEC_VW | Variable down step (used in variable mode) |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | W | Software write value |
| count | output | W | Current count |
| at_upper | output | 1 | Count at or above the upper threshold |
| at_lower | output | 1 | Count at or below the lower threshold |
| ovf_pulse | output | 1 | One-cycle wrap-past-maximum pulse |
| unf_pulse | output | 1 | One-cycle wrap-below-zero pulse |

## Verification
Two events can fall in the same cycle:
- The up and down strobes can both be high. The test drives both, with a variable step on one side, and expects the count to move by the difference. In the wrapping instance it also drives two equal steps and expects no change and no pulse.
- A software write can arrive while a strobe is high. The test raises a write together with a strobe whose step alone would change the count or cause a wrap. It then expects exactly the written value and no pulse in the next cycle.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum int {
    STEP_UNIT  = 0,
    STEP_FIXED = 1,
    STEP_VAR   = 2
  } step_mode_e;
endpackage

// File: rtl/ctr_step_sel.sv
module ctr_step_sel #(
  parameter int W = 8,
  parameter ctr_pkg::step_mode_e MODE = ctr_pkg::STEP_UNIT,
  parameter int FIXED = 1,
  parameter int VW = 1
) (
  input  logic          stb,
  input  logic [VW-1:0] amt,
  output logic [W-1:0]  step
);
  logic [W-1:0] raw_step;

  generate
    if (MODE == ctr_pkg::STEP_VAR) begin : g_var
      assign raw_step = W'(amt);
    end else if (MODE == ctr_pkg::STEP_FIXED) begin : g_fixed
      logic unused_amt;
      assign unused_amt = ^amt;
      assign raw_step = W'(FIXED);
    end else begin : g_unit
      logic unused_amt;
      assign unused_amt = ^amt;
      assign raw_step = W'(1);
    end
  endgenerate

  assign step = stb ? raw_step : '0;
endmodule

// File: rtl/ctr_next.sv
module ctr_next #(
  parameter int W = 8,
  parameter bit INC_SAT_EN = 1'b1,
  parameter int INC_CEIL = (1 << W) - 1,
  parameter bit DEC_SAT_EN = 1'b1,
  parameter int DEC_FLOOR = 0
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] up_step,
  input  logic [W-1:0] dn_step,
  output logic [W-1:0] nxt,
  output logic         wrap_up,
  output logic         wrap_dn,
  output logic         sat_hi,
  output logic         sat_lo
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] CEIL_S  = EW'(INC_CEIL);
  localparam logic signed [EW-1:0] FLOOR_S = EW'(DEC_FLOOR);
  localparam logic signed [EW-1:0] MAX_S   = EW'((1 << W) - 1);

  function automatic logic signed [EW-1:0] widen(input logic [W-1:0] v);
    return $signed({2'b00, v});
  endfunction

  function automatic logic signed [EW-1:0] raw_sum(input logic [W-1:0] c,
                                                  input logic [W-1:0] u,
                                                  input logic [W-1:0] d);
    return widen(c) + widen(u) - widen(d);
  endfunction

  logic signed [EW-1:0] sum;
  logic going_up, going_dn;

  assign sum      = raw_sum(cur, up_step, dn_step);
  assign going_up = up_step > dn_step;
  assign going_dn = dn_step > up_step;

  always_comb begin
    nxt     = sum[W-1:0];
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    sat_hi  = 1'b0;
    sat_lo  = 1'b0;
    if (going_up) begin
      if (INC_SAT_EN) begin
        if (sum > CEIL_S) begin
          nxt    = CEIL_S[W-1:0];
          sat_hi = 1'b1;
        end
      end else begin
        wrap_up = sum > MAX_S;
      end
    end else if (going_dn) begin
      if (DEC_SAT_EN) begin
        if (sum < FLOOR_S) begin
          nxt    = FLOOR_S[W-1:0];
          sat_lo = 1'b1;
        end
      end else begin
        wrap_dn = sum < 0;
      end
    end
  end
endmodule

// File: rtl/ctr_field.sv
module ctr_field #(
  parameter int W = 8,
  parameter ctr_pkg::step_mode_e INC_MODE = ctr_pkg::STEP_UNIT,
  parameter int INC_FIXED = 1,
  parameter int INC_VW = 4,
  parameter ctr_pkg::step_mode_e DEC_MODE = ctr_pkg::STEP_UNIT,
  parameter int DEC_FIXED = 1,
  parameter int DEC_VW = 4,
  parameter bit INC_SAT_EN = 1'b1,
  parameter int INC_CEIL = (1 << W) - 1,
  parameter bit DEC_SAT_EN = 1'b1,
  parameter int DEC_FLOOR = 0,
  parameter int INC_THR = (1 << W) - 1,
  parameter int DEC_THR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              incr_stb,
  input  logic [INC_VW-1:0] incr_amt,
  input  logic              decr_stb,
  input  logic [DEC_VW-1:0] decr_amt,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      count,
  output logic              at_upper,
  output logic              at_lower,
  output logic              ovf_pulse,
  output logic              unf_pulse
);
  localparam logic [W-1:0] THR_HI = W'(INC_THR);
  localparam logic [W-1:0] THR_LO = W'(DEC_THR);

  logic [W-1:0] count_q;
  logic [W-1:0] up_step, dn_step, nxt;
  logic ev_wrap_up, ev_wrap_dn, ev_sat_hi, ev_sat_lo, ev_sw_write;
  logic ovf_q, unf_q;

  ctr_step_sel #(.W(W), .MODE(INC_MODE), .FIXED(INC_FIXED), .VW(INC_VW)) u_up (
    .stb(incr_stb), .amt(incr_amt), .step(up_step)
  );

  ctr_step_sel #(.W(W), .MODE(DEC_MODE), .FIXED(DEC_FIXED), .VW(DEC_VW)) u_dn (
    .stb(decr_stb), .amt(decr_amt), .step(dn_step)
  );

  ctr_next #(
    .W(W), .INC_SAT_EN(INC_SAT_EN), .INC_CEIL(INC_CEIL),
    .DEC_SAT_EN(DEC_SAT_EN), .DEC_FLOOR(DEC_FLOOR)
  ) u_nxt (
    .cur(count_q), .up_step(up_step), .dn_step(dn_step), .nxt(nxt),
    .wrap_up(ev_wrap_up), .wrap_dn(ev_wrap_dn),
    .sat_hi(ev_sat_hi), .sat_lo(ev_sat_lo)
  );

  assign ev_sw_write = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else if (ev_sw_write) begin
      count_q <= wr_data;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      count_q <= nxt;
      ovf_q   <= ev_wrap_up;
      unf_q   <= ev_wrap_dn;
    end
  end

  function automatic logic ge_thr(input logic [W-1:0] v, input logic [W-1:0] t);
    return v >= t;
  endfunction

  function automatic logic le_thr(input logic [W-1:0] v, input logic [W-1:0] t);
    return v <= t;
  endfunction

  assign count     = count_q;
  assign at_upper  = ge_thr(count_q, THR_HI);
  assign at_lower  = le_thr(count_q, THR_LO);
  assign ovf_pulse = ovf_q;
  assign unf_pulse = unf_q;
endmodule

// File: rtl/ctr_field_chk.sv
module ctr_field_chk #(
  parameter int W = 8,
  parameter bit INC_SAT_EN = 1'b1,
  parameter int INC_CEIL = 255,
  parameter bit DEC_SAT_EN = 1'b1,
  parameter int DEC_FLOOR = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         incr_stb,
  input logic         decr_stb,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         ovf_pulse,
  input logic         unf_pulse,
  input logic         ev_wrap_up,
  input logic         ev_wrap_dn
);
  localparam logic [W-1:0] CEIL_V  = W'(INC_CEIL);
  localparam logic [W-1:0] FLOOR_V = W'(DEC_FLOOR);

  // R11: a write loads the written value
  a_r11_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));

  // R11: a write suppresses both pulses
  a_r11_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ovf_pulse && !unf_pulse);

  // R12: idle cycle holds the count
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !incr_stb && !decr_stb) |=> $stable(count));

  // R7: an overflow pulse follows a wrap event and the count went down numerically
  a_r7_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap_up && !wr_en) |=> ovf_pulse && (count < $past(count)));

  // R8: an underflow pulse follows a wrap event and the count went up numerically
  a_r8_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap_dn && !wr_en) |=> unf_pulse && (count > $past(count)));

  // R7, R8: the two pulses never overlap
  a_r8_pulses_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_pulse, unf_pulse}));

  // R5: with both directions saturating, counting never leaves the ceiling
  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (INC_SAT_EN && DEC_SAT_EN && !wr_en && count <= CEIL_V) |=> count <= CEIL_V);

  // R6: with both directions saturating, counting never goes under the floor
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (INC_SAT_EN && DEC_SAT_EN && !wr_en && count >= FLOOR_V) |=> count >= FLOOR_V);
endmodule

bind ctr_field ctr_field_chk #(
  .W(W), .INC_SAT_EN(INC_SAT_EN), .INC_CEIL(INC_CEIL),
  .DEC_SAT_EN(DEC_SAT_EN), .DEC_FLOOR(DEC_FLOOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .incr_stb(incr_stb), .decr_stb(decr_stb),
  .wr_en(wr_en), .wr_data(wr_data), .count(count),
  .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
  .ev_wrap_up(ev_wrap_up), .ev_wrap_dn(ev_wrap_dn)
);

// File: tb/sim_ctr_field.sv
module sim_ctr_field;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // instance 0: variable up step, fixed down step of 3, saturating
  logic       a_inc = 0, a_dec = 0, a_wr = 0;
  logic [3:0] a_amt = 0;
  logic [7:0] a_wd = 0;
  logic [7:0] a_cnt;
  logic a_up, a_lo, a_ovf, a_unf;

  // instance 1: unit up step, variable down step, wrapping, default thresholds
  logic       b_inc = 0, b_dec = 0, b_wr = 0;
  logic [3:0] b_amt = 0;
  logic [7:0] b_wd = 0;
  logic [7:0] b_cnt;
  logic b_up, b_lo, b_ovf, b_unf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  ctr_field #(
    .W(8), .INC_MODE(ctr_pkg::STEP_VAR), .INC_VW(4),
    .DEC_MODE(ctr_pkg::STEP_FIXED), .DEC_FIXED(3), .DEC_VW(4),
    .INC_SAT_EN(1'b1), .INC_CEIL(200), .DEC_SAT_EN(1'b1), .DEC_FLOOR(10),
    .INC_THR(180), .DEC_THR(20)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .incr_stb(a_inc), .incr_amt(a_amt),
    .decr_stb(a_dec), .decr_amt(4'd0), .wr_en(a_wr), .wr_data(a_wd),
    .count(a_cnt), .at_upper(a_up), .at_lower(a_lo),
    .ovf_pulse(a_ovf), .unf_pulse(a_unf)
  );

  ctr_field #(
    .W(8), .INC_MODE(ctr_pkg::STEP_UNIT), .INC_VW(4),
    .DEC_MODE(ctr_pkg::STEP_VAR), .DEC_VW(4),
    .INC_SAT_EN(1'b0), .DEC_SAT_EN(1'b0)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .incr_stb(b_inc), .incr_amt(4'd0),
    .decr_stb(b_dec), .decr_amt(b_amt), .wr_en(b_wr), .wr_data(b_wd),
    .count(b_cnt), .at_upper(b_up), .at_lower(b_lo),
    .ovf_pulse(b_ovf), .unf_pulse(b_unf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle on instance 0, then sample at the following falling edge
  task automatic cyc_a(input bit inc, input int amt, input bit dec,
                       input bit wr, input int wd);
    a_inc = inc; a_amt = 4'(amt); a_dec = dec; a_wr = wr; a_wd = 8'(wd);
    @(posedge clk);
    @(negedge clk);
    a_inc = 0; a_dec = 0; a_wr = 0;
  endtask

  task automatic cyc_b(input bit inc, input bit dec, input int amt,
                       input bit wr, input int wd);
    b_inc = inc; b_dec = dec; b_amt = 4'(amt); b_wr = wr; b_wd = 8'(wd);
    @(posedge clk);
    @(negedge clk);
    b_inc = 0; b_dec = 0; b_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 u0 count", a_cnt, 0);
    chk("R1 u0 pulses", {a_ovf, a_unf}, 0);
    chk("R10 u0 at_lower at 0", a_lo, 1);
    chk("R9 u0 at_upper at 0", a_up, 0);
    chk("R1 u1 count", b_cnt, 0);
    chk("R1 u1 pulses", {b_ovf, b_unf}, 0);
  endtask

  task automatic t_write_priority;
    cyc_a(1, 5, 0, 1, 100);
    chk("R11 write beats up strobe", a_cnt, 100);
    chk("R11 no pulse on write", {a_ovf, a_unf}, 0);
    cyc_b(0, 1, 5, 1, 0);
    chk("R11 write beats down strobe u1", b_cnt, 0);
    chk("R11 no underflow on write u1", b_unf, 0);
  endtask

  task automatic t_steps;
    cyc_a(1, 7, 0, 0, 0);
    chk("R2 variable up 7", a_cnt, 107);
    cyc_a(1, 15, 0, 0, 0);
    chk("R2 variable up 15", a_cnt, 122);
    cyc_a(0, 0, 1, 0, 0);
    chk("R3 fixed down 3", a_cnt, 119);
    cyc_a(0, 9, 0, 0, 0);
    chk("R12 hold", a_cnt, 119);
    cyc_a(1, 5, 1, 0, 0);
    chk("R4 net up5 down3", a_cnt, 121);
    cyc_a(1, 2, 1, 0, 0);
    chk("R4 net negative", a_cnt, 120);
  endtask

  task automatic t_ceiling;
    cyc_a(0, 0, 0, 1, 195);
    cyc_a(1, 9, 0, 0, 0);
    chk("R5 clamp at ceiling", a_cnt, 200);
    chk("R9 at_upper above thr", a_up, 1);
    chk("R5 no ovf when saturating", a_ovf, 0);
    cyc_a(1, 1, 0, 0, 0);
    chk("R5 stays at ceiling", a_cnt, 200);
    cyc_a(0, 0, 0, 1, 179);
    chk("R9 at_upper below thr", a_up, 0);
    cyc_a(1, 1, 0, 0, 0);
    chk("R9 at_upper at thr", a_up, 1);
  endtask

  task automatic t_floor;
    cyc_a(0, 0, 0, 1, 21);
    chk("R10 at_lower above thr", a_lo, 0);
    cyc_a(0, 0, 1, 0, 0);
    chk("R3 down to 18", a_cnt, 18);
    chk("R10 at_lower below thr", a_lo, 1);
    cyc_a(0, 0, 1, 0, 0);
    cyc_a(0, 0, 1, 0, 0);
    chk("R3 down to 12", a_cnt, 12);
    cyc_a(0, 0, 1, 0, 0);
    chk("R6 clamp at floor", a_cnt, 10);
    chk("R6 no unf when saturating", a_unf, 0);
    cyc_a(0, 0, 1, 0, 0);
    chk("R6 stays at floor", a_cnt, 10);
    cyc_a(0, 0, 0, 1, 20);
    chk("R10 at_lower at thr", a_lo, 1);
  endtask

  task automatic t_wrap;
    cyc_b(0, 0, 0, 1, 254);
    chk("R9 default thr not reached", b_up, 0);
    cyc_b(1, 0, 0, 0, 0);
    chk("R2 unit up step", b_cnt, 255);
    chk("R9 default thr reached", b_up, 1);
    cyc_b(1, 0, 0, 0, 0);
    chk("R7 wrap to 0", b_cnt, 0);
    chk("R7 ovf pulse", b_ovf, 1);
    chk("R10 default lower thr", b_lo, 1);
    cyc_b(0, 0, 0, 0, 0);
    chk("R7 ovf one cycle", b_ovf, 0);
    cyc_b(0, 1, 2, 0, 0);
    chk("R8 wrap below 0", b_cnt, 254);
    chk("R8 unf pulse", b_unf, 1);
    cyc_b(0, 0, 0, 0, 0);
    chk("R8 unf one cycle", b_unf, 0);
    chk("R12 hold u1", b_cnt, 254);
    cyc_b(1, 1, 1, 0, 0);
    chk("R4 equal steps no change", b_cnt, 254);
    chk("R4 no pulse on zero net", {b_ovf, b_unf}, 0);
    cyc_b(0, 0, 0, 1, 255);
    cyc_b(1, 0, 0, 1, 255);
    chk("R11 write beats wrap", b_cnt, 255);
    chk("R11 no ovf on write", b_ovf, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_priority();
    t_steps();
    t_ceiling();
    t_floor();
    t_wrap();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule